// File: doc/BRIEF.md
# Banked Register File Address Decoder

This block turns every data-memory access of a small 8-bit core into one physical location and holds the general purpose bytes behind it. Each access carries a 5-bit location taken from the instruction word. A 7-bit pointer register, held inside the block, supplies a 2-bit bank number in its upper bits. Location 0 is not storage: an access to it is indirect, and the pointer's own 7 bits become the bank and location.

The data space has four banks of 32 locations. The lower 16 locations of every bank fold onto bank 0, so they are the same physical registers from any bank. Locations 1 to 7 are special function registers. The pointer register lives at location 4 and is kept here; the other six go out to neighbouring logic through a select, an index and a write strobe. Locations 8 to 15 are 8 shared RAM bytes. Locations 16 to 31 are 16 RAM bytes per bank, which with the shared bytes gives 72 bytes.

An indirect access whose pointer names location 0 refers to itself. It reads as zero and writes nothing. Reads follow the address with no clock in the path. Writes take effect on the rising clock edge while the write enable is high. The resolved 7-bit physical address is brought out for checking.

Top module: `rfd_decoder`

## Requirements
- R1: While reset is asserted and after it is released, the pointer register holds 0, so a read of location 4 returns 80h.
- R2: Location 4, in any bank and whether reached directly or indirectly, is the pointer register. A write stores data bits 6:0 and drops bit 7. A read returns 1 in bit 7 and the stored 7 bits below it.
- R3: For a direct access (location 1 to 31), the bank is pointer bits 6:5. When the location is 10h or above, phys_addr_o is {bank, location}: bank in bits 6:5 and location in bits 4:0.
- R4: A location below 10h maps to bank 0 whatever the pointer's bank bits are, so phys_addr_o bits 6:5 are 00 for it.
- R5: Location 0 is indirect. indirect_o is 1, and pointer bits 6:5 and 4:0 act as the bank and location of the access, both for reads and for writes.
- R6: An indirect access whose pointer bits 4:0 are 0 reads 00h and reports phys_addr_o 00h. With the write enable high it changes no RAM byte and no pointer bit, and it keeps sfr_we_o low.
- R7: Locations 1, 2, 3, 5, 6 and 7 assert sfr_sel_o. sfr_idx_o carries the location number, rd_data_o returns sfr_rd_data_i, and sfr_we_o follows wr_en_i. Every other location keeps sfr_sel_o and sfr_we_o low.
- R8: Locations 08h to 0Fh are one set of 8 bytes, shared by all banks. A byte written from any bank reads back from every bank.
- R9: Locations 10h to 1Fh are 16 separate bytes in each of the 4 banks, 64 bytes in all. A write in one bank leaves the same location in the other banks unchanged.
- R10: rd_data_o follows the address with no clock edge in between. A write takes effect on the rising edge only while wr_en_i is 1; with wr_en_i at 0, storage and the pointer hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes happen on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| dir_addr_i | input | 5 | Location from the instruction word; 0 selects indirect access |
| wr_en_i | input | 1 | Write enable for the current access |
| wr_data_i | input | 8 | Byte to write |
| sfr_rd_data_i | input | 8 | Read data returned by the external special function register selected by sfr_idx_o |
| rd_data_o | output | 8 | Read data of the resolved location |
| phys_addr_o | output | 7 | Resolved physical address: bank in bits 6:5, location in bits 4:0 |
| indirect_o | output | 1 | High when the access goes through the pointer |
| sfr_sel_o | output | 1 | An external special function register is addressed |
| sfr_idx_o | output | 3 | Number of the addressed special function register |
| sfr_we_o | output | 1 | Write strobe for the addressed external register |

## Verification
The assertions check these rules on every cycle: a folded location always reports bank 0, a banked location always carries the pointer's bank bits, a pointer read always has bit 7 set, the external write strobe never reaches location 0 or location 4, a self-referencing write leaves the pointer untouched, and the pointer changes only through a write. What the storage holds can only be shown by the bench's scenarios. These include the sharing of locations 08h to 0Fh across banks, the separation of the banked bytes, and a null write that leaves all RAM intact. They also cover reads through every one of the 128 pointer values, checked against a model of the bytes written before.

// File: rtl/rfd_pkg.sv
package rfd_pkg;
  localparam int DATA_W_D  = 8;
  localparam int DIR_W_D   = 5;
  localparam int PTR_W_D   = 7;
  localparam int SFR_N_D   = 8;
  localparam int PTR_LOC_D = 4;

  typedef enum logic [2:0] {
    HIT_NULL,
    HIT_SFR,
    HIT_PTR,
    HIT_SHARED,
    HIT_BANKED
  } hit_e;
endpackage

// File: rtl/rfd_resolve.sv
module rfd_resolve
  import rfd_pkg::*;
#(
  parameter int DIR_W   = DIR_W_D,
  parameter int PTR_W   = PTR_W_D,
  parameter int SFR_N   = SFR_N_D,
  parameter int PTR_LOC = PTR_LOC_D
) (
  input  logic [DIR_W-1:0]       dir_addr_i,
  input  logic [PTR_W-1:0]       ptr_i,
  output logic [PTR_W-1:0]       phys_o,
  output logic [DIR_W-1:0]       loc_o,
  output logic [PTR_W-DIR_W-1:0] bank_o,
  output logic                   is_ind_o,
  output hit_e                   hit_o
);
  localparam int BANK_W = PTR_W - DIR_W;

  logic folded;

  always_comb begin
    is_ind_o = (dir_addr_i == '0);
    loc_o    = is_ind_o ? ptr_i[DIR_W-1:0] : dir_addr_i;
    bank_o   = ptr_i[PTR_W-1:DIR_W];
    folded   = !loc_o[DIR_W-1];
    if (loc_o == '0) begin
      hit_o  = HIT_NULL;
      phys_o = '0;
    end else begin
      phys_o = folded ? {{BANK_W{1'b0}}, loc_o} : {bank_o, loc_o};
      if (loc_o < DIR_W'(SFR_N)) begin
        hit_o = (loc_o == DIR_W'(PTR_LOC)) ? HIT_PTR : HIT_SFR;
      end else if (folded) begin
        hit_o = HIT_SHARED;
      end else begin
        hit_o = HIT_BANKED;
      end
    end
  end
endmodule

// File: rtl/rfd_ptr.sv
module rfd_ptr #(
  parameter int PTR_W  = rfd_pkg::PTR_W_D,
  parameter int DATA_W = rfd_pkg::DATA_W_D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [PTR_W-1:0]  wr_data_i,
  output logic [PTR_W-1:0]  ptr_o,
  output logic [DATA_W-1:0] rd_o
);
  localparam int PAD_W = DATA_W - PTR_W;

  logic [PTR_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (we_i) ptr_d = wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;
  assign rd_o  = {{PAD_W{1'b1}}, ptr_q};

  // R2: a write loads the stored bits on the next edge
  p_ptr_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (ptr_q == $past(wr_data_i)));

  // R10: without a write the pointer holds
  p_ptr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(ptr_q));
endmodule

// File: rtl/rfd_gpr.sv
module rfd_gpr
  import rfd_pkg::*;
#(
  parameter int DATA_W = DATA_W_D,
  parameter int DIR_W  = DIR_W_D,
  parameter int BANK_W = PTR_W_D - DIR_W_D,
  parameter int SFR_N  = SFR_N_D
) (
  input  logic              clk,
  input  hit_e              hit_i,
  input  logic [DIR_W-1:0]  loc_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_o
);
  localparam int HALF     = (1 << DIR_W) / 2;
  localparam int SHARED_N = HALF - SFR_N;
  localparam int NBANK    = 1 << BANK_W;
  localparam int GPR_N    = SHARED_N + NBANK * HALF;
  localparam int IDX_W    = $clog2(GPR_N);

  logic [DATA_W-1:0] mem [GPR_N];
  logic [IDX_W-1:0]  idx;
  logic              ram_we;
  logic [GPR_N-1:0]  we_vec;
  int                tmp;

  always_comb begin
    tmp = 0;
    if (hit_i == HIT_SHARED) tmp = int'(loc_i) - SFR_N;
    else if (hit_i == HIT_BANKED) tmp = SHARED_N + int'(bank_i) * HALF + int'(loc_i) - HALF;
    idx    = IDX_W'(tmp);
    ram_we = wr_en_i && ((hit_i == HIT_SHARED) || (hit_i == HIT_BANKED));
  end

  for (genvar g = 0; g < GPR_N; g++) begin : g_we
    assign we_vec[g] = ram_we && (idx == IDX_W'(g));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < GPR_N; i++) begin
      if (we_vec[i]) mem[i] <= wr_data_i;
    end
  end

  assign rd_o = mem[idx];
endmodule

// File: rtl/rfd_decoder.sv
module rfd_decoder
  import rfd_pkg::*;
#(
  parameter int DATA_W  = DATA_W_D,
  parameter int DIR_W   = DIR_W_D,
  parameter int PTR_W   = PTR_W_D,
  parameter int SFR_N   = SFR_N_D,
  parameter int PTR_LOC = PTR_LOC_D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIR_W-1:0]  dir_addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [DATA_W-1:0] sfr_rd_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [PTR_W-1:0]  phys_addr_o,
  output logic              indirect_o,
  output logic              sfr_sel_o,
  output logic [$clog2(SFR_N)-1:0] sfr_idx_o,
  output logic              sfr_we_o
);
  localparam int BANK_W = PTR_W - DIR_W;
  localparam int SIDX_W = $clog2(SFR_N);

  logic              rst_m, rst_q;
  logic [PTR_W-1:0]  ptr_q;
  logic [DATA_W-1:0] ptr_rd, gpr_rd;
  logic [DIR_W-1:0]  loc;
  logic [BANK_W-1:0] bank;
  logic              ptr_we;
  hit_e              hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_q <= rst_m;
    end
  end

  rfd_resolve #(
    .DIR_W(DIR_W), .PTR_W(PTR_W), .SFR_N(SFR_N), .PTR_LOC(PTR_LOC)
  ) u_resolve (
    .dir_addr_i(dir_addr_i),
    .ptr_i     (ptr_q),
    .phys_o    (phys_addr_o),
    .loc_o     (loc),
    .bank_o    (bank),
    .is_ind_o  (indirect_o),
    .hit_o     (hit)
  );

  assign ptr_we = wr_en_i && (hit == HIT_PTR);

  rfd_ptr #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_q),
    .we_i     (ptr_we),
    .wr_data_i(wr_data_i[PTR_W-1:0]),
    .ptr_o    (ptr_q),
    .rd_o     (ptr_rd)
  );

  rfd_gpr #(
    .DATA_W(DATA_W), .DIR_W(DIR_W), .BANK_W(BANK_W), .SFR_N(SFR_N)
  ) u_gpr (
    .clk      (clk),
    .hit_i    (hit),
    .loc_i    (loc),
    .bank_i   (bank),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .rd_o     (gpr_rd)
  );

  always_comb begin
    sfr_sel_o = (hit == HIT_SFR);
    sfr_idx_o = loc[SIDX_W-1:0];
    sfr_we_o  = sfr_sel_o && wr_en_i;
    case (hit)
      HIT_SFR:    rd_data_o = sfr_rd_data_i;
      HIT_PTR:    rd_data_o = ptr_rd;
      HIT_SHARED,
      HIT_BANKED: rd_data_o = gpr_rd;
      default:    rd_data_o = '0;
    endcase
  end

  // R4: a folded location always reports bank 0
  p_fold_bank0_r4: assert property (@(posedge clk) disable iff (!rst_q)
    !phys_addr_o[DIR_W-1] |-> (phys_addr_o[PTR_W-1:DIR_W] == '0));

  // R3: a banked location carries the pointer's bank bits
  p_banked_bank_r3: assert property (@(posedge clk) disable iff (!rst_q)
    phys_addr_o[DIR_W-1] |-> (phys_addr_o[PTR_W-1:DIR_W] == ptr_q[PTR_W-1:DIR_W]));

  // R2: a pointer read always shows the unimplemented top bit as 1
  p_ptr_msb_r2: assert property (@(posedge clk) disable iff (!rst_q)
    (hit == HIT_PTR) |-> rd_data_o[DATA_W-1]);

  // R7: the external strobe never reaches location 0 or the pointer
  p_sfr_we_r7: assert property (@(posedge clk) disable iff (!rst_q)
    sfr_we_o |-> ((sfr_idx_o != SIDX_W'(PTR_LOC)) && (sfr_idx_o != '0) && !phys_addr_o[DIR_W-2]));

  // R6: a self-referencing write leaves the pointer alone
  p_null_write_r6: assert property (@(posedge clk) disable iff (!rst_q)
    (indirect_o && (phys_addr_o == '0) && wr_en_i) |=> $stable(ptr_q));
endmodule

// File: tb/rfd_decoder_tb.sv
`timescale 1ns/1ps
module rfd_decoder_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] dir;
  logic       we;
  logic [7:0] wd, sfr_rd;
  logic [7:0] rd;
  logic [6:0] phys;
  logic       ind, ssel, swe;
  logic [2:0] sidx;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;
  logic [7:0] mdl [72];

  always #5 clk = ~clk;

  rfd_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .dir_addr_i(dir), .wr_en_i(we), .wr_data_i(wd),
    .sfr_rd_data_i(sfr_rd), .rd_data_o(rd), .phys_addr_o(phys), .indirect_o(ind),
    .sfr_sel_o(ssel), .sfr_idx_o(sidx), .sfr_we_o(swe)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int gidx(int b, int l);
    return (l < 16) ? (l - 8) : (8 + b * 16 + l - 16);
  endfunction

  function automatic int exp_rd(int pv, int l);
    if (l == 0) return 0;
    if (l == 4) return 128 + pv;
    if (l < 8)  return int'(sfr_rd);
    return int'(mdl[gidx(pv / 32, l)]);
  endfunction

  function automatic int exp_phys(int pv, int l);
    if (l == 0)  return 0;
    if (l < 16)  return l;
    return (pv / 32) * 32 + l;
  endfunction

  task automatic wr(int a, int d);
    @(negedge clk);
    dir = 5'(a); wd = 8'(d); we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic look(int a);
    @(negedge clk);
    dir = 5'(a);
    #1;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog R10 actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    dir = 5'd4; we = 1'b0; wd = 8'h00; sfr_rd = 8'hA5;
    #1;
    chk("R1 pointer in reset", int'(rd), 8'h80);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    look(4);
    chk("R1 pointer after reset", int'(rd), 8'h80);

    // Fill RAM from every bank
    for (int b = 0; b < 4; b++) begin
      wr(4, b * 32 + 17);
      for (int a = 8; a < 32; a++) begin
        int v;
        v = (b * 53 + a * 7 + 3) & 255;
        wr(a, v);
        mdl[gidx(b, a)] = 8'(v);
      end
    end

    // External register strobes (R7)
    for (int a = 1; a < 8; a++) begin
      @(negedge clk);
      dir = 5'(a); wd = 8'h3C; we = 1'b1;
      #1;
      chk("R7 sfr_sel", int'(ssel), (a != 4) ? 1 : 0);
      chk("R7 sfr_we", int'(swe), (a != 4) ? 1 : 0);
      if (a != 4) chk("R7 sfr_idx", int'(sidx), a);
      @(negedge clk);
      we = 1'b0;
      #1;
      chk("R7 sfr_we low without write", int'(swe), 0);
    end
    wr(4, 17);

    // Direct sweep over all banks and locations
    for (int b = 0; b < 4; b++) begin
      int pv;
      pv = b * 32 + 17;
      wr(4, pv);
      for (int a = 1; a < 32; a++) begin
        look(a);
        chk(a < 16 ? "R4 direct folded read" : "R9 direct banked read", int'(rd), exp_rd(pv, a));
        chk(a < 16 ? "R4 folded phys" : "R3 banked phys", int'(phys), exp_phys(pv, a));
        chk("R5 indirect flag direct", int'(ind), 0);
      end
    end

    // Shared bytes come from the last bank written, banked bytes stay apart
    wr(4, 0);
    look(9);
    chk("R8 shared visible in bank 0", int'(rd), (3 * 53 + 9 * 7 + 3) & 255);
    look(20);
    chk("R9 bank 0 byte kept", int'(rd), (0 * 53 + 20 * 7 + 3) & 255);

    // Indirect sweep over every pointer value
    sfr_rd = 8'h5A;
    for (int p = 0; p < 128; p++) begin
      wr(4, p);
      look(0);
      chk("R5 indirect flag", int'(ind), 1);
      chk((p % 32 == 0) ? "R6 null read" : "R5 indirect read", int'(rd), exp_rd(p, p % 32));
      chk((p % 32 == 0) ? "R6 null phys" : "R5 indirect phys", int'(phys), exp_phys(p, p % 32));
    end

    // Null writes change nothing
    for (int b = 0; b < 4; b++) begin
      wr(4, b * 32);
      @(negedge clk);
      dir = 5'd0; wd = 8'hE7; we = 1'b1;
      #1;
      chk("R6 null write no strobe", int'(swe), 0);
      @(negedge clk);
      we = 1'b0;
      look(4);
      chk("R6 null write pointer kept", int'(rd), 128 + b * 32);
      look(16);
      chk("R6 null write RAM kept", int'(rd), int'(mdl[gidx(b, 16)]));
    end

    // Indirect writes
    wr(4, 2 * 32 + 19);
    wr(0, 8'h77);
    mdl[gidx(2, 19)] = 8'h77;
    wr(4, 2 * 32 + 5);
    look(19);
    chk("R5 indirect write seen directly", int'(rd), 8'h77);
    wr(4, 3 * 32 + 9);
    wr(0, 8'h3E);
    mdl[gidx(3, 9)] = 8'h3E;
    wr(4, 32);
    look(9);
    chk("R8 shared write from bank 3 seen in bank 1", int'(rd), 8'h3E);
    look(19);
    chk("R9 bank 1 unaffected by bank 2 write", int'(rd), int'(mdl[gidx(1, 19)]));

    // Pointer bits
    wr(4, 32 + 4);
    wr(0, 8'h15);
    look(4);
    chk("R2 indirect pointer write", int'(rd), 8'h95);
    wr(4, 8'hFF);
    look(4);
    chk("R2 top bit dropped", int'(rd), 8'hFF);
    wr(4, 8'h80);
    look(4);
    chk("R2 top bit reads one", int'(rd), 8'h80);
    wr(4, 8'h40);
    look(4);
    chk("R2 pointer in bank 2 via direct", int'(rd), 8'hC0);

    // No write without enable
    @(negedge clk);
    dir = 5'd16; wd = 8'h00; we = 1'b0;
    @(negedge clk);
    look(16);
    chk("R10 no write without enable", int'(rd), int'(mdl[gidx(2, 16)]));
    @(negedge clk);
    dir = 5'd4; wd = 8'h01; we = 1'b0;
    @(negedge clk);
    look(4);
    chk("R10 pointer held without enable", int'(rd), 8'hC0);
    dir = 5'd16;
    #1;
    chk("R10 read follows address", int'(rd), int'(mdl[gidx(2, 16)]));

    done = 1'b1;
    finish_run();
  end
endmodule